// File: doc/BRIEF.md
# Bridge Protection Supervisor

This block sits between the sensing front end of a power half-bridge array and the gate-drive enable. Every clock it looks at one current code per half bridge, a junction-temperature code and a supply-voltage code, plus two control inputs: a run request and an active-low high-impedance request. From these it produces a single bridge-enable, an active-low fault flag and an active-low thermal-warning flag. Over-current and over-temperature cut the enable in the same cycle they appear, because the path from the sensor codes to the enable and fault outputs contains no register.

Over-current and thermal-shutdown events are latched. Software or board logic clears a latched fault by taking the high-impedance request low and then high again while the cause is gone. Thermal shutdown carries hysteresis, and a warning threshold sits below it. An optional internal timer, picked by a parameter, clears the latch by itself at fixed intervals once the cause has gone. This models the arrangement where the fault flag is fed back into the high-impedance input through a delay. Undervoltage is not latched. The bridge comes back after the supply code has stayed valid for a settle count, and the same settle count applies after reset.

Codes are unsigned integers. Temperature is in whole degrees Celsius. Supply is in units of 100 mV. Time is in clock cycles.

Top module: `bridge_guard`

## Requirements
- R1: If any half-bridge current code is at or above OC_LIMIT (default 220), then drive_en_o is low and fault_n_o is low in that same cycle. A code of 219 has no effect.
- R2: A temperature code at or above SHUT_C (default 150) drives drive_en_o low and fault_n_o low in that same cycle. A code of 149 does not trip shutdown.
- R3: Once shutdown has tripped, the thermal cause persists until the temperature code falls to SHUT_C minus HYST_C (default 125) or below. A clear sequence performed at 126 leaves fault_n_o low.
- R4: twarn_n_o is low exactly when the temperature code is at or above WARN_C (default 130). This holds whatever the fault, run and high-impedance state, so the warning is always low during thermal shutdown.
- R5: A tripped fault stays latched after its cause goes away. It clears, with fault_n_o high one cycle later, only on a rising edge of hiz_n_i that occurs with no cause present and that follows a falling edge of hiz_n_i seen since the fault latched. A rise with no fall since the trip does not clear it.
- R6: A supply code below UV_CODE (default 70) drives drive_en_o low in the same cycle and leaves fault_n_o high. A code of exactly 70 counts as valid. The bridge re-enables without any toggle after SETTLE_CYC consecutive clock edges with a valid supply.
- R7: After reset, drive_en_o stays low until SETTLE_CYC (default 16) clock edges have passed with a valid supply code. It is low after 15 such edges and high after 16.
- R8: run_i low or hiz_n_i low forces drive_en_o low in the same cycle. Neither raises a fault.
- R9: With RETRY_EN set, a latched fault clears by itself on the RETRY_CYC-th clock edge after it latched if no cause is present in the preceding cycle. If a cause is still present, the interval restarts.
- R10: While rst_n is low, drive_en_o is low. With clean inputs, fault_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run request; low powers the bridge down |
| hiz_n_i | input | 1 | Active-low high-impedance request; its low-high toggle clears a latched fault |
| cur_code_i | input | NUM_HB*CUR_W | One current code per half bridge; half bridge i is at bits [i*CUR_W +: CUR_W] |
| temp_code_i | input | TEMP_W | Junction temperature in degrees Celsius |
| supply_code_i | input | SUP_W | Supply voltage in units of 100 mV |
| drive_en_o | output | 1 | Bridge enable; low places every output in high impedance |
| fault_n_o | output | 1 | Active-low fault flag for over-current or thermal shutdown |
| twarn_n_o | output | 1 | Active-low thermal warning |

## Verification
The bound checker examines every cycle for several properties. It checks that over-current, shutdown temperature, undervoltage, a low run request and a low high-impedance request each hold the enable low in the same cycle. It checks that a latched fault never releases without a rising high-impedance edge when retry is off, and that the enable never rises before the supply has been valid for the settle count. Other behaviour depends on history and only the bench scenarios show it: the exact settle and retry cycle counts, the 126-versus-125 hysteresis boundary, and the rule that a rising edge with no fall since the trip does not clear the latch.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;

    // Phase of the latched-fault clear sequence.
    typedef enum logic [1:0] {
        PH_CLEAR  = 2'd0,   // no fault held
        PH_ARMED  = 2'd1,   // fault held, waiting for hiz request to fall
        PH_PRIMED = 2'd2    // fall seen, a clean rise releases the fault
    } latch_phase_e;

endpackage

// File: rtl/bridge_guard_thermal.sv
module bridge_guard_thermal #(
    parameter int TEMP_W = 8,
    parameter int SHUT_C = 150,
    parameter int REL_C  = 125,
    parameter int WARN_C = 130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              hot_o,
    output logic              warn_o
);

    localparam logic [TEMP_W-1:0] SHUT_LIM = TEMP_W'(SHUT_C);
    localparam logic [TEMP_W-1:0] REL_LIM  = TEMP_W'(REL_C);
    localparam logic [TEMP_W-1:0] WARN_LIM = TEMP_W'(WARN_C);

    typedef struct packed {
        logic tripped;
    } tstate_t;

    tstate_t q, d;
    logic    at_shut;
    logic    at_rel;

    always_comb begin
        at_shut = (temp_i >= SHUT_LIM);
        at_rel  = (temp_i <= REL_LIM);
        d       = q;
        if (at_shut) begin
            d.tripped = 1'b1;
        end else if (at_rel) begin
            d.tripped = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Trip acts in the cycle the code arrives; hysteresis holds it after.
    assign hot_o  = at_shut | q.tripped;
    assign warn_o = (temp_i >= WARN_LIM);

endmodule

// File: rtl/bridge_guard_supply.sv
module bridge_guard_supply #(
    parameter int SUP_W      = 10,
    parameter int UV_CODE    = 70,
    parameter int SETTLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUP_W-1:0] supply_i,
    output logic             ok_o
);

    localparam int               CW      = $clog2(SETTLE_CYC + 1);
    localparam logic [SUP_W-1:0] UV_LIM  = SUP_W'(UV_CODE);
    localparam logic [CW-1:0]    CNT_TOP = CW'(SETTLE_CYC);

    typedef struct packed {
        logic [CW-1:0] valid_cnt;
    } sstate_t;

    sstate_t q, d;
    logic    under;
    logic    settled;

    always_comb begin
        under   = (supply_i < UV_LIM);
        settled = (q.valid_cnt == CNT_TOP);
        d       = q;
        if (under) begin
            d.valid_cnt = '0;
        end else if (!settled) begin
            d.valid_cnt = q.valid_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ok_o = settled & ~under;

endmodule

// File: rtl/bridge_guard_latch.sv
module bridge_guard_latch #(
    parameter bit RETRY_EN  = 1'b0,
    parameter int RETRY_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    input  logic hiz_n_i,
    output logic latched_o
);
    import bridge_guard_pkg::*;

    localparam int            RW      = $clog2(RETRY_CYC + 1);
    localparam logic [RW-1:0] RT_LAST = RW'(RETRY_CYC - 1);

    typedef struct packed {
        latch_phase_e  phase;
        logic          hiz_prev;
        logic [RW-1:0] rtmr;
    } lstate_t;

    lstate_t q, d;
    logic    fell;
    logic    rose;
    logic    held;
    logic    retry_due;

    always_comb begin
        d          = q;
        d.hiz_prev = hiz_n_i;
        fell       = q.hiz_prev & ~hiz_n_i;
        rose       = ~q.hiz_prev & hiz_n_i;
        held       = (q.phase != PH_CLEAR);
        retry_due  = RETRY_EN && held && (q.rtmr == RT_LAST);

        // Retry interval timer, counting only while a fault is held.
        if (RETRY_EN && held) begin
            d.rtmr = retry_due ? '0 : q.rtmr + 1'b1;
        end else begin
            d.rtmr = '0;
        end

        unique case (q.phase)
            PH_CLEAR:  if (cause_i) d.phase = PH_ARMED;
            PH_ARMED:  if (fell)    d.phase = PH_PRIMED;
            PH_PRIMED: if (rose)    d.phase = cause_i ? PH_ARMED : PH_CLEAR;
            default:                d.phase = PH_ARMED;
        endcase

        if (retry_due && !cause_i) begin
            d.phase = PH_CLEAR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_CLEAR, hiz_prev: 1'b0, rtmr: '0};
        end else begin
            q <= d;
        end
    end

    assign latched_o = (q.phase != PH_CLEAR);

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard #(
    parameter int NUM_HB     = 4,
    parameter int CUR_W      = 8,
    parameter int TEMP_W     = 8,
    parameter int SUP_W      = 10,
    parameter int OC_LIMIT   = 220,
    parameter int WARN_C     = 130,
    parameter int SHUT_C     = 150,
    parameter int HYST_C     = 25,
    parameter int UV_CODE    = 70,
    parameter int SETTLE_CYC = 16,
    parameter bit RETRY_EN   = 1'b0,
    parameter int RETRY_CYC  = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic                    hiz_n_i,
    input  logic [NUM_HB*CUR_W-1:0] cur_code_i,
    input  logic [TEMP_W-1:0]       temp_code_i,
    input  logic [SUP_W-1:0]        supply_code_i,
    output logic                    drive_en_o,
    output logic                    fault_n_o,
    output logic                    twarn_n_o
);

    localparam int               REL_C  = SHUT_C - HYST_C;
    localparam logic [CUR_W-1:0] OC_LIM = CUR_W'(OC_LIMIT);

    logic [NUM_HB-1:0] oc_hb;
    logic              over_cur;
    logic              hot;
    logic              warn;
    logic              supply_ok;
    logic              cause;
    logic              latched;

    // One comparator per half bridge.
    for (genvar g = 0; g < NUM_HB; g++) begin : g_oc
        assign oc_hb[g] = (cur_code_i[g*CUR_W +: CUR_W] >= OC_LIM);
    end

    assign over_cur = |oc_hb;

    bridge_guard_thermal #(
        .TEMP_W (TEMP_W),
        .SHUT_C (SHUT_C),
        .REL_C  (REL_C),
        .WARN_C (WARN_C)
    ) u_thermal (
        .clk    (clk),
        .rst_n  (rst_n),
        .temp_i (temp_code_i),
        .hot_o  (hot),
        .warn_o (warn)
    );

    bridge_guard_supply #(
        .SUP_W      (SUP_W),
        .UV_CODE    (UV_CODE),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_supply (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_i (supply_code_i),
        .ok_o     (supply_ok)
    );

    assign cause = over_cur | hot;

    bridge_guard_latch #(
        .RETRY_EN  (RETRY_EN),
        .RETRY_CYC (RETRY_CYC)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_i   (cause),
        .hiz_n_i   (hiz_n_i),
        .latched_o (latched)
    );

    // Zero-cycle cut: live causes act before the latch registers them.
    assign drive_en_o = supply_ok & run_i & hiz_n_i & ~cause & ~latched;
    assign fault_n_o  = ~(cause | latched);
    assign twarn_n_o  = ~warn;

endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk #(
    parameter int NUM_HB     = 4,
    parameter int CUR_W      = 8,
    parameter int TEMP_W     = 8,
    parameter int SUP_W      = 10,
    parameter int OC_LIMIT   = 220,
    parameter int SHUT_C     = 150,
    parameter int UV_CODE    = 70,
    parameter int SETTLE_CYC = 16,
    parameter bit RETRY_EN   = 1'b0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run_i,
    input logic                    hiz_n_i,
    input logic [NUM_HB*CUR_W-1:0] cur_code_i,
    input logic [TEMP_W-1:0]       temp_code_i,
    input logic [SUP_W-1:0]        supply_code_i,
    input logic                    drive_en_o,
    input logic                    fault_n_o,
    input logic                    twarn_n_o
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic          any_oc;
    logic          hot_now;
    logic          low_sup;
    logic [CW-1:0] vcnt_q;

    always_comb begin
        any_oc = 1'b0;
        for (int i = 0; i < NUM_HB; i++) begin
            if (cur_code_i[i*CUR_W +: CUR_W] >= CUR_W'(OC_LIMIT)) any_oc = 1'b1;
        end
        hot_now = (temp_code_i >= TEMP_W'(SHUT_C));
        low_sup = (supply_code_i < SUP_W'(UV_CODE));
    end

    // Independent count of consecutive valid-supply edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcnt_q <= '0;
        end else if (low_sup) begin
            vcnt_q <= '0;
        end else if (vcnt_q != CW'(SETTLE_CYC)) begin
            vcnt_q <= vcnt_q + 1'b1;
        end
    end

    assert_oc_cut_R1: assert property (@(posedge clk) disable iff (!rst_n)
        any_oc |-> (!drive_en_o && !fault_n_o));

    assert_hot_cut_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hot_now |-> (!drive_en_o && !fault_n_o));

    assert_warn_in_shutdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hot_now |-> !twarn_n_o);

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((RETRY_EN == 1'b0) && !fault_n_o && !$rose(hiz_n_i)) |=> !fault_n_o);

    assert_uv_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        low_sup |-> !drive_en_o);

    assert_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_o |-> (vcnt_q == CW'(SETTLE_CYC)));

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || !hiz_n_i) |-> !drive_en_o);

    assert_reset_off_R10: assert property (@(posedge clk)
        !rst_n |-> !drive_en_o);

endmodule

bind bridge_guard bridge_guard_chk #(
    .NUM_HB     (NUM_HB),
    .CUR_W      (CUR_W),
    .TEMP_W     (TEMP_W),
    .SUP_W      (SUP_W),
    .OC_LIMIT   (OC_LIMIT),
    .SHUT_C     (SHUT_C),
    .UV_CODE    (UV_CODE),
    .SETTLE_CYC (SETTLE_CYC),
    .RETRY_EN   (RETRY_EN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run_i),
    .hiz_n_i       (hiz_n_i),
    .cur_code_i    (cur_code_i),
    .temp_code_i   (temp_code_i),
    .supply_code_i (supply_code_i),
    .drive_en_o    (drive_en_o),
    .fault_n_o     (fault_n_o),
    .twarn_n_o     (twarn_n_o)
);

// File: tb/test_bridge_guard.sv
module test_bridge_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic        hiz;
    logic [31:0] cur;
    logic [7:0]  temp;
    logic [9:0]  sup;
    logic        en, fn, wn;
    logic        en_r, fn_r, wn_r;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bridge_guard i_bridge_guard (
        .clk(clk), .rst_n(rst_n), .run_i(run), .hiz_n_i(hiz),
        .cur_code_i(cur), .temp_code_i(temp), .supply_code_i(sup),
        .drive_en_o(en), .fault_n_o(fn), .twarn_n_o(wn)
    );

    bridge_guard #(.RETRY_EN(1'b1), .RETRY_CYC(40)) i_bridge_guard_retry (
        .clk(clk), .rst_n(rst_n), .run_i(run), .hiz_n_i(hiz),
        .cur_code_i(cur), .temp_code_i(temp), .supply_code_i(sup),
        .drive_en_o(en_r), .fault_n_o(fn_r), .twarn_n_o(wn_r)
    );

    typedef struct packed {
        logic [1:0] hb;
        logic [7:0] cval;
        logic [7:0] t;
        logic [9:0] s;
        logic       r;
        logic       h;
        logic       x_en;
        logic       x_fn;
        logic       x_wn;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd0,   8'd25,  10'd120, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'd0,   8'd129, 10'd120, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'd0,   8'd130, 10'd120, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{2'd0, 8'd0,   8'd149, 10'd120, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{2'd3, 8'd219, 8'd25,  10'd120, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'd0,   8'd25,  10'd70,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'd0,   8'd25,  10'd120, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{2'd0, 8'd0,   8'd25,  10'd120, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'd0, 8'd0,   8'd135, 10'd120, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd0, 8'd0,   8'd25,  10'd120, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'd0,   8'd25,  10'd69,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    function automatic string vec_tag(int i);
        case (i)
            1, 2, 8: return "R4";
            3:       return "R2";
            4:       return "R1";
            5, 10:   return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check_bit(input string tag, input string what,
                             input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input string what,
                             input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_cur(input int hb, input logic [7:0] v);
        cur = '0;
        cur[hb*8 +: 8] = v;
    endtask

    // hiz low for one edge, high again; sample one cycle after the rise edge.
    task automatic toggle_hiz();
        @(negedge clk); hiz = 1'b0;
        @(negedge clk); hiz = 1'b1;
        @(negedge clk); #1;
    endtask

    // Count settle edges after a valid supply returns (R6 / R7).
    task automatic settle_run(input string tag);
        for (int k = 1; k <= 16; k++) begin
            @(posedge clk);
            @(negedge clk); #1;
            if (k == 15) check_bit(tag, "enable after 15 valid edges", en, 1'b0);
            if (k == 16) check_bit(tag, "enable after 16 valid edges", en, 1'b1);
        end
    endtask

    // Retry instance: trip on half bridge 1, hold the cause for hold cycles.
    task automatic retry_run(input int hold, input int exp_n);
        int n;
        @(negedge clk); set_cur(1, 8'd230);
        @(posedge clk);
        n = 0;
        while (n < 300) begin
            @(negedge clk);
            if (n == hold) cur = '0;
            #1;
            if (fn_r) break;
            @(posedge clk);
            n++;
        end
        check_int("R9", "edges until self clear", n, exp_n);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; run = 1'b1; hiz = 1'b1; cur = '0; temp = 8'd25; sup = 10'd120;
        repeat (3) @(negedge clk);
        #1;
        check_bit("R10", "enable in reset", en, 1'b0);
        check_bit("R10", "fault flag in reset", fn, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        settle_run("R7");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_cur(int'(VECS[i].hb), VECS[i].cval);
            temp = VECS[i].t; sup = VECS[i].s; run = VECS[i].r; hiz = VECS[i].h;
            #1;
            check_bit(vec_tag(i), $sformatf("vec %0d enable", i), en, VECS[i].x_en);
            check_bit(vec_tag(i), $sformatf("vec %0d fault", i), fn, VECS[i].x_fn);
            check_bit(vec_tag(i), $sformatf("vec %0d warn", i), wn, VECS[i].x_wn);
        end

        // R6: undervoltage holds, no fault, then recovers without toggle
        repeat (3) @(negedge clk);
        #1;
        check_bit("R6", "fault during undervoltage", fn, 1'b1);
        check_bit("R6", "enable during undervoltage", en, 1'b0);
        @(negedge clk); sup = 10'd120;
        settle_run("R6");

        // R1: over-current on half bridge 2, then R5 latch and clear
        @(negedge clk); set_cur(2, 8'd220);
        #1;
        check_bit("R1", "enable at over-current", en, 1'b0);
        check_bit("R1", "fault at over-current", fn, 1'b0);
        @(negedge clk); cur = '0;
        #1;
        check_bit("R5", "fault held after cause gone", fn, 1'b0);
        repeat (5) @(negedge clk);
        #1;
        check_bit("R5", "enable held off", en, 1'b0);
        toggle_hiz();
        check_bit("R5", "fault cleared by toggle", fn, 1'b1);
        check_bit("R5", "enable after clear", en, 1'b1);

        // R5: fault trips while hiz is already low; a bare rise must not clear
        @(negedge clk); hiz = 1'b0;
        @(negedge clk); set_cur(3, 8'd255);
        #1;
        check_bit("R1", "fault with hiz low", fn, 1'b0);
        @(negedge clk); cur = '0;
        @(negedge clk); hiz = 1'b1;
        @(negedge clk); #1;
        check_bit("R5", "rise without fall keeps fault", fn, 1'b0);
        toggle_hiz();
        check_bit("R5", "full toggle clears", fn, 1'b1);

        // R2 / R3: shutdown with hysteresis
        @(negedge clk); temp = 8'd150;
        #1;
        check_bit("R2", "enable at 150", en, 1'b0);
        check_bit("R2", "fault at 150", fn, 1'b0);
        check_bit("R4", "warn at 150", wn, 1'b0);
        @(negedge clk); temp = 8'd126;
        #1;
        check_bit("R3", "still shut at 126", fn, 1'b0);
        check_bit("R4", "warn released at 126", wn, 1'b1);
        toggle_hiz();
        check_bit("R3", "toggle at 126 does not clear", fn, 1'b0);
        @(negedge clk); temp = 8'd125;
        @(negedge clk); #1;
        check_bit("R5", "latched after release at 125", fn, 1'b0);
        toggle_hiz();
        check_bit("R3", "clear after cooling to 125", fn, 1'b1);
        check_bit("R3", "enable after cooling", en, 1'b1);

        // R9: internal retry timer
        repeat (60) @(negedge clk);
        temp = 8'd25;
        retry_run(0, 40);
        check_bit("R5", "no self clear without retry", fn, 1'b0);
        repeat (50) @(negedge clk);
        retry_run(60, 80);

        summary();
        $finish;
    end

endmodule